// File: doc/BRIEF.md
# Dual-Mode Output Voltage PI Compensator

This block closes the slow outer voltage loop of a boost power-factor stage. Every accepted output-voltage sample is compared with a reference. While that error stays small, the loop does not regulate on the live sample. It regulates on a copy of the output voltage taken at the most recent mains zero crossing. That copy equals the mean bus voltage, so the twice-line-frequency ripple never enters the loop. A low proportional/integral gain pair is used in this case.

When a load step pushes the live error beyond a programmable threshold, the loop switches over. It regulates on the live sample with a high gain pair so the bus recovers quickly. It returns to the held value once the error falls below the threshold less a hysteresis margin.

The result is a saturated current-amplitude command for the inner current loop.

The mode controller is a two-state machine:
- State `MODE_HOLD` is the reset state and uses the held value with the slow gains.
- State `MODE_LIVE` uses the live sample with the fast gains.
- Transition HOLD→LIVE ("engage") fires on an accepted sample whose error magnitude is strictly above the threshold.
- Transition LIVE→HOLD ("release") fires on an accepted sample whose error magnitude is strictly below threshold minus hysteresis, floored at zero.

All other cases keep the current state.

Top module: `vloop_pi_ctrl`

## Requirements
- R1: After reset the command is 0, the integrator is 0, the held and last-sample registers are 0, and the mode is HOLD (`mode_fast` = 0).
- R2: On a `zc_pulse` cycle the held value takes the most recent accepted sample. A sample accepted in that same cycle takes precedence. The new held value is first used by the next accepted sample.
- R3: In HOLD mode an accepted sample updates the loop with error = `vref` − held value and gains `kp_slow`/`ki_slow`. The live sample only influences the mode decision.
- R4: An accepted sample with |`vref` − sample| > `err_thr` moves HOLD to LIVE. That same sample is processed with error = `vref` − sample and gains `kp_fast`/`ki_fast`.
- R5: In LIVE mode the state returns to HOLD only when |`vref` − sample| < `err_thr` − `err_hyst` (0 if the hysteresis exceeds the threshold). The sample that releases is processed in HOLD mode.
- R6: Without `smp_valid` the mode, integrator and command do not change.
- R7: The integrator adds ki·error on every accepted sample. It is clamped to [`cmd_min`·2^F, `cmd_max`·2^F], where F = 8 fraction bits at the default parameters.
- R8: The command is floor((kp·error + integrator) / 2^F), clamped to [`cmd_min`, `cmd_max`]. It is registered, so it appears one clock after the accepted sample.
- R9: All data are two's complement. The gains are signed Q(GW−F).F values, so 0x0100 means 1.0 at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe; one accepted sample per high cycle |
| smp_vout | input | DW | Signed output-voltage sample |
| zc_pulse | input | 1 | Mains zero-crossing pulse |
| vref | input | DW | Signed voltage reference |
| err_thr | input | DW | Unsigned error threshold for LIVE mode |
| err_hyst | input | DW | Unsigned hysteresis below the threshold |
| kp_slow | input | GW | Proportional gain, HOLD mode (signed Q) |
| ki_slow | input | GW | Integral gain, HOLD mode (signed Q) |
| kp_fast | input | GW | Proportional gain, LIVE mode (signed Q) |
| ki_fast | input | GW | Integral gain, LIVE mode (signed Q) |
| cmd_min | input | OW | Signed lower command limit |
| cmd_max | input | OW | Signed upper command limit |
| iamp_cmd | output | OW | Saturated current-amplitude command |
| mode_fast | output | 1 | 1 while the state is LIVE |

## Verification
The hardest cases to reach from the ports are the two edges of the hysteresis band: an error equal to the threshold, and an error between the release level and the threshold while in LIVE. Each must keep the state where it is.

The bench steps the sample through a ladder of values around the reference. The ladder lands exactly on the threshold, one count above it, and inside the band from both directions. It also interleaves zero-crossing pulses, including one that coincides with a strobe.

A long run against the upper limit winds the integrator into its clamp. A reversal that follows then shows whether the clamp held the integrator at the limit or let it wind past it.

// File: rtl/vloop_pkg.sv
`timescale 1ns/1ps
package vloop_pkg;
    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_LIVE = 1'b1
    } vmode_t;
endpackage

// File: rtl/vloop_zc_hold.sv
`timescale 1ns/1ps
module vloop_zc_hold #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic                 zc,
    input  logic signed [DW-1:0] sample,
    output logic signed [DW-1:0] held
);
    logic signed [DW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            held   <= '0;
        end else begin
            if (upd) last_q <= sample;
            if (zc)  held   <= upd ? sample : last_q;
        end
    end

    // R2: a coinciding strobe is the value captured
    a_r2_zc_takes_new: assert property (@(posedge clk) disable iff (!rst_n)
        (zc && upd) |=> (held == $past(sample)));
endmodule

// File: rtl/vloop_mode_fsm.sv
`timescale 1ns/1ps
module vloop_mode_fsm
    import vloop_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [DW-1:0] sample,
    input  logic signed [DW-1:0] vref,
    input  logic        [DW-1:0] thr,
    input  logic        [DW-1:0] hyst,
    output vmode_t               mode_nx,
    output vmode_t               mode_q
);
    localparam int EW = DW + 1;

    logic signed [EW-1:0] ierr;
    logic        [EW-1:0] mag;
    logic        [EW-1:0] hi_lvl;
    logic        [EW-1:0] lo_lvl;

    always_comb begin
        ierr   = EW'(vref) - EW'(sample);
        mag    = ierr[EW-1] ? EW'(-ierr) : EW'(ierr);
        hi_lvl = {1'b0, thr};
        lo_lvl = (hyst > thr) ? '0 : {1'b0, thr - hyst};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_HOLD;
        else        mode_q <= mode_nx;
    end

    always_comb begin
        mode_nx = mode_q;
        unique case (mode_q)
            MODE_HOLD: if (upd && (mag > hi_lvl)) mode_nx = MODE_LIVE;
            MODE_LIVE: if (upd && (mag < lo_lvl)) mode_nx = MODE_HOLD;
            default:   mode_nx = MODE_HOLD;
        endcase
    end

    a_r4_engage: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (mag > hi_lvl)) |=> (mode_q == MODE_LIVE));
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (mag < lo_lvl)) |=> (mode_q == MODE_HOLD));
    a_r5_band_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (mag <= hi_lvl) && (mag >= lo_lvl)) |=> $stable(mode_q));
    a_r6_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(mode_q));
endmodule

// File: rtl/vloop_pi_core.sv
`timescale 1ns/1ps
module vloop_pi_core #(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 8,
    parameter int OW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [DW-1:0] fb,
    input  logic signed [DW-1:0] vref,
    input  logic signed [GW-1:0] kp,
    input  logic signed [GW-1:0] ki,
    input  logic signed [OW-1:0] lim_lo,
    input  logic signed [OW-1:0] lim_hi,
    output logic signed [OW-1:0] cmd
);
    localparam int EW = DW + 1;
    localparam int PW = EW + GW;
    localparam int AW = ((PW > OW + FRAC) ? PW : OW + FRAC) + 2;

    logic signed [EW-1:0] err;
    logic signed [AW-1:0] p_term, i_term;
    logic signed [AW-1:0] acc_q, acc_sum, acc_nx;
    logic signed [AW-1:0] acc_lo, acc_hi;
    logic signed [AW-1:0] total, scaled, out_lo, out_hi, out_sat;

    always_comb begin
        err     = EW'(vref) - EW'(fb);
        p_term  = AW'(err) * AW'(kp);
        i_term  = AW'(err) * AW'(ki);
        out_lo  = AW'(lim_lo);
        out_hi  = AW'(lim_hi);
        acc_lo  = out_lo <<< FRAC;
        acc_hi  = out_hi <<< FRAC;
        acc_sum = acc_q + i_term;
        if (acc_sum > acc_hi)      acc_nx = acc_hi;
        else if (acc_sum < acc_lo) acc_nx = acc_lo;
        else                       acc_nx = acc_sum;
        total   = p_term + acc_nx;
        scaled  = total >>> FRAC;
        if (scaled > out_hi)       out_sat = out_hi;
        else if (scaled < out_lo)  out_sat = out_lo;
        else                       out_sat = scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cmd   <= '0;
        end else if (upd) begin
            acc_q <= acc_nx;
            cmd   <= OW'(out_sat);
        end
    end

    a_r6_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(cmd) && $stable(acc_q)));
    a_r7_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (lim_lo <= lim_hi)) |=>
        ((acc_q <= (AW'($past(lim_hi)) <<< FRAC)) && (acc_q >= (AW'($past(lim_lo)) <<< FRAC))));
    a_r8_cmd_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (lim_lo <= lim_hi)) |=> ((cmd <= $past(lim_hi)) && (cmd >= $past(lim_lo))));
endmodule

// File: rtl/vloop_pi_ctrl.sv
`timescale 1ns/1ps
module vloop_pi_ctrl
    import vloop_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 8,
    parameter int OW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_vout,
    input  logic                 zc_pulse,
    input  logic signed [DW-1:0] vref,
    input  logic        [DW-1:0] err_thr,
    input  logic        [DW-1:0] err_hyst,
    input  logic signed [GW-1:0] kp_slow,
    input  logic signed [GW-1:0] ki_slow,
    input  logic signed [GW-1:0] kp_fast,
    input  logic signed [GW-1:0] ki_fast,
    input  logic signed [OW-1:0] cmd_min,
    input  logic signed [OW-1:0] cmd_max,
    output logic signed [OW-1:0] iamp_cmd,
    output logic                 mode_fast
);
    vmode_t               mode_nx, mode_q;
    logic signed [DW-1:0] held;
    logic signed [DW-1:0] fb_sel;
    logic signed [GW-1:0] kp_sel, ki_sel;

    vloop_zc_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .upd(smp_valid), .zc(zc_pulse),
        .sample(smp_vout), .held(held)
    );

    vloop_mode_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .upd(smp_valid), .sample(smp_vout),
        .vref(vref), .thr(err_thr), .hyst(err_hyst),
        .mode_nx(mode_nx), .mode_q(mode_q)
    );

    always_comb begin
        unique case (mode_nx)
            MODE_LIVE: begin fb_sel = smp_vout; kp_sel = kp_fast; ki_sel = ki_fast; end
            default:   begin fb_sel = held;     kp_sel = kp_slow; ki_sel = ki_slow; end
        endcase
        mode_fast = (mode_q == MODE_LIVE);
    end

    vloop_pi_core #(.DW(DW), .GW(GW), .FRAC(FRAC), .OW(OW)) u_pi (
        .clk(clk), .rst_n(rst_n), .upd(smp_valid), .fb(fb_sel), .vref(vref),
        .kp(kp_sel), .ki(ki_sel), .lim_lo(cmd_min), .lim_hi(cmd_max),
        .cmd(iamp_cmd)
    );

    // R1: reset state seen at the ports
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> ((iamp_cmd == '0) && !mode_fast) || !rst_n);
endmodule

// File: tb/vloop_pi_ctrl_test.sv
`timescale 1ns/1ps
module vloop_pi_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic zc_pulse = 1'b0;
    logic signed [15:0] smp_vout = '0;
    logic signed [15:0] vref = 16'sd1000;
    logic        [15:0] err_thr = 16'd100;
    logic        [15:0] err_hyst = 16'd30;
    logic signed [15:0] kp_slow = 16'sh0080;
    logic signed [15:0] ki_slow = 16'sh0010;
    logic signed [15:0] kp_fast = 16'sh0400;
    logic signed [15:0] ki_fast = 16'sh0080;
    logic signed [15:0] cmd_min = 16'sd0;
    logic signed [15:0] cmd_max = 16'sd4000;
    logic signed [15:0] iamp_cmd;
    logic               mode_fast;

    int n_chk = 0;
    int n_bad = 0;

    longint m_acc = 0, m_held = 0, m_last = 0, m_cmd = 0;
    bit     m_live = 1'b0;

    always #4 clk = ~clk;

    vloop_pi_ctrl uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_vout(smp_vout),
        .zc_pulse(zc_pulse), .vref(vref), .err_thr(err_thr), .err_hyst(err_hyst),
        .kp_slow(kp_slow), .ki_slow(ki_slow), .kp_fast(kp_fast), .ki_fast(ki_fast),
        .cmd_min(cmd_min), .cmd_max(cmd_max), .iamp_cmd(iamp_cmd), .mode_fast(mode_fast)
    );

    function automatic longint clampl(longint x, longint lo, longint hi);
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // model of R2..R8 applied to one clock's inputs
    task automatic model(input bit v, input longint s, input bit z);
        longint mag, lo, fb, e, kp, ki, held_old;
        held_old = m_held;
        if (z) m_held = v ? s : m_last;
        if (v) begin
            m_last = s;
            mag = longint'(vref) - s;
            if (mag < 0) mag = -mag;
            lo = (err_hyst > err_thr) ? 0 : longint'(err_thr) - longint'(err_hyst);
            if (!m_live && mag > longint'(err_thr)) m_live = 1'b1;
            else if (m_live && mag < lo)             m_live = 1'b0;
            fb = m_live ? s : held_old;
            kp = m_live ? longint'(kp_fast) : longint'(kp_slow);
            ki = m_live ? longint'(ki_fast) : longint'(ki_slow);
            e  = longint'(vref) - fb;
            m_acc = clampl(m_acc + ki * e, longint'(cmd_min) * 256, longint'(cmd_max) * 256);
            m_cmd = clampl((kp * e + m_acc) >>> 8, longint'(cmd_min), longint'(cmd_max));
        end
    endtask

    task automatic step(input bit v, input int s, input bit z, input string tag);
        @(negedge clk);
        smp_valid = v; smp_vout = 16'(s); zc_pulse = z;
        @(posedge clk);
        model(v, longint'(s), z);
        #2;
        check(tag, longint'(iamp_cmd), m_cmd);
        check(tag, longint'(mode_fast), longint'(m_live));
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cmd", longint'(iamp_cmd), 0);
        check("R1 reset mode", longint'(mode_fast), 0);
        rst_n = 1'b1;

        // R2 latch a sample at a zero crossing, then regulate on it (R3)
        step(1'b1, 1010, 1'b1, "R2");
        step(1'b1, 1040, 1'b0, "R3");
        step(1'b0, 1090, 1'b1, "R2");
        step(1'b1, 960,  1'b0, "R3");
        step(1'b1, 1050, 1'b0, "R3");

        // R5 hysteresis ladder: thr 100, release below 70
        step(1'b1, 1100, 1'b0, "R5");
        step(1'b1, 1101, 1'b0, "R4");
        step(1'b1, 1080, 1'b0, "R5");
        step(1'b1, 1070, 1'b0, "R5");
        step(1'b1, 1069, 1'b0, "R5");
        step(1'b1, 1090, 1'b1, "R5");
        step(1'b1, 880,  1'b0, "R4");
        step(1'b1, 950,  1'b0, "R5");

        // R6 idle cycles with large swings must change nothing
        for (int k = 0; k < 8; k++) step(1'b0, 200 + k * 300, 1'b0, "R6");

        // sweep of samples around the reference with periodic crossings
        for (int s = 600; s <= 1400; s += 25) step(1'b1, s, (s % 100) == 0, "R3");
        for (int s = 1400; s >= 600; s -= 40) step(1'b1, s, (s % 120) == 0, "R4");

        // R8 / R7: drive into the upper limit, then reverse
        for (int k = 0; k < 20; k++) step(1'b1, 0, 1'b0, "R8");
        step(1'b1, 1200, 1'b0, "R7");
        step(1'b1, 1200, 1'b0, "R7");
        // negative lower limit with output pulled down
        cmd_min = -16'sd300;
        for (int k = 0; k < 20; k++) step(1'b1, 1800, 1'b0, "R8");
        step(1'b1, 700, 1'b0, "R7");

        // hysteresis larger than threshold: release level is 0 (R5)
        err_hyst = 16'd200;
        step(1'b1, 1000, 1'b1, "R5");
        step(1'b1, 1001, 1'b0, "R5");
        err_hyst = 16'd30;
        // gain sweep with signed Q8.8 values (R9)
        for (int g = 0; g < 4; g++) begin
            kp_slow = 16'(64 * (g + 1));
            ki_slow = 16'(8 * g);
            step(1'b1, 1000 + 10 * g, 1'b1, "R9");
            step(1'b1, 990 - 10 * g, 1'b0, "R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule